// File: doc/BRIEF.md
# Staged Configuration Register File

This block holds the control settings of a cartridge memory controller behind a CPU bus. The settings are sixteen one-bit registers placed in a window of the 24-bit address space. Each register is carried on data bit 7. The bank number selects which register is addressed. The mapping settings are double-buffered. A write lands in a pending copy, and the memory mapper keeps using the active copy until software writes a commit. The commit copies every pending bit into the active copy at once, so a remap never passes through a half-updated state.

The bank also holds an interrupt enable, which is written directly, and a read-only interrupt flag. The flag is set by a pulse from the interrupt logic and cleared only by reset. A separate 8-bit extended register can take over the window. Once software switches it in, every access in the window reaches one of its bits, including the access that would normally switch it back out. It stays selected until reset. Reads outside the window, or cycles without a read strobe, pass the incoming bus data through unchanged.

Top module: `cfg_stage_regs`

## Requirements
- R1: The window is hit when (address AND 0xF0F000) equals 0x005000, i.e. banks 0x00-0x0F at offsets 0x5000-0x5FFF. The register index is address bits 19:16; the low 12 address bits are ignored.
- R2: A read inside the window (read strobe high) returns the selected bit in data bit 7, with bits 6:0 zero. A write uses only data bit 7.
- R3: In normal mode, writes to indexes 2-13 change only the pending copy. The active outputs and the read value of those indexes (which show the active copy) do not change until a commit.
- R4: A write to index 14 with bit 7 set copies the whole pending copy into the active copy on that clock edge, so the new settings are visible from the next cycle. A write to index 14 with bit 7 clear changes nothing.
- R5: In normal mode, indexes 14 and 15 read as zero.
- R6: Index 1 is the interrupt enable and takes effect at once without a commit. Index 0 reads the interrupt flag. The flag is set by `irq_set`, ignores bus writes and is cleared only by reset.
- R7: The active bits map to outputs by index: 2 address-line-15 mapping mode, 3 PSRAM low enable, 4 PSRAM high enable, 5 PSRAM window bit 0, 6 PSRAM window bit 1, 7 ROM low enable, 8 ROM high enable, 9 expansion low enable, 10 expansion high enable, 11 expansion window, 12 flash writable, 13 spare.
- R8: A normal-mode write to index 15 with bit 7 set enters extended mode. Extended mode is left only by reset.
- R9: In extended mode, every read and write in the window addresses bit (index AND 7) of the 8-bit extended value, carried on data bit 7. Index 14 and index 15 are redirected too, so a write there neither commits nor leaves extended mode. The configuration outputs do not change.
- R10: After a synchronous active-high reset, both copies hold mapping 1, PSRAM low 1, PSRAM high 0, PSRAM window 3, ROM low 1, ROM high 1, expansion low 1, expansion high 0, expansion window 1, flash writable 0 and spare 0. The interrupt flag and enable are 0, extended mode is off and the extended value is 0x3F.
- R11: Outside the window, or when the read strobe is low, `bus_rdata` equals `bus_rdata_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_addr | input | 24 | CPU address |
| bus_wdata | input | 8 | Write data; bit 7 carries the register bit |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rdata_in | input | 8 | Incoming read data from other bus devices |
| bus_rdata | output | 8 | Read data, passed through outside the window |
| irq_set | input | 1 | Pulse that sets the interrupt flag |
| irq_flag | output | 1 | Interrupt flag |
| irq_enable | output | 1 | Interrupt enable |
| cfg_map_a15 | output | 1 | Active mapping mode (1 uses address line 15) |
| cfg_psram_lo_en | output | 1 | Active PSRAM low-half enable |
| cfg_psram_hi_en | output | 1 | Active PSRAM high-half enable |
| cfg_psram_win | output | 2 | Active PSRAM window select |
| cfg_rom_lo_en | output | 1 | Active ROM low enable |
| cfg_rom_hi_en | output | 1 | Active ROM high enable |
| cfg_exp_lo_en | output | 1 | Active expansion low enable |
| cfg_exp_hi_en | output | 1 | Active expansion high enable |
| cfg_exp_win | output | 1 | Active expansion window select |
| cfg_flash_wr_en | output | 1 | Active flash-pack writable |
| cfg_spare | output | 1 | Active spare bit |

## Verification
The hardest state to reach is extended mode after the configuration has already been changed and committed. The redirected window has to be told apart from the normal one there: index 6 must return extended bit 6 and not the committed window bit, and writes to index 14 and 15 must neither commit nor leave the mode. The stimulus first commits settings that differ from the reset values. It then enters extended mode and hits each of the special indexes, checking both the read value and the unchanged outputs. A final reset shows that only reset leaves the mode.

// File: rtl/cfg_stage_pkg.sv
package cfg_stage_pkg;

  // Register index layout: this order is decoded by software.
  localparam int IRQ_FLAG_IDX = 0;
  localparam int IRQ_EN_IDX   = 1;
  localparam int STAGE_FIRST  = 2;
  localparam int STAGE_LAST   = 13;
  localparam int COMMIT_IDX   = 14;
  localparam int EXT_IDX      = 15;
  localparam int STAGE_N      = STAGE_LAST - STAGE_FIRST + 1;

  // Reset pattern of the staged bits, bit k holds index k+2.
  localparam logic [STAGE_N-1:0] STAGE_RESET = 12'h2FB;

  typedef struct packed {
    logic       spare;
    logic       flash_wr;
    logic       exp_win;
    logic       exp_hi;
    logic       exp_lo;
    logic       rom_hi;
    logic       rom_lo;
    logic [1:0] psram_win;
    logic       psram_hi;
    logic       psram_lo;
    logic       map_a15;
  } cfg_t;

  // Staged vector bit k belongs to register index k+2; the struct is laid out to match.
  function automatic cfg_t cfg_from_vec(input logic [STAGE_N-1:0] v);
    cfg_t c;
    c = cfg_t'(v);
    return c;
  endfunction

  function automatic logic idx_is_staged(input logic [3:0] idx);
    return (int'(idx) >= STAGE_FIRST) && (int'(idx) <= STAGE_LAST);
  endfunction

endpackage

// File: rtl/cfg_win_decode.sv
module cfg_win_decode #(
  parameter int                ADDR_W    = 24,
  parameter int                IDX_W     = 4,
  parameter int                IDX_LSB   = 16,
  parameter logic [ADDR_W-1:0] WIN_MASK  = 24'hF0F000,
  parameter logic [ADDR_W-1:0] WIN_MATCH = 24'h005000
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  idx
);
  assign hit = (addr & WIN_MASK) == WIN_MATCH;
  assign idx = addr[IDX_LSB +: IDX_W];
endmodule

// File: rtl/cfg_stage_bank.sv
module cfg_stage_bank #(
  parameter int               N     = 12,
  parameter logic [N-1:0]     RESET = '0,
  localparam int              SEL_W = $clog2(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wr_bit,
  input  logic             commit,
  output logic [N-1:0]     pend,
  output logic [N-1:0]     act
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst) begin
        pend[i] <= RESET[i];
        act[i]  <= RESET[i];
      end else begin
        if (wr_en && (wr_sel == SEL_W'(i))) pend[i] <= wr_bit;
        if (commit) act[i] <= pend[i];
      end
    end
  end
endmodule

// File: rtl/cfg_ext_reg.sv
module cfg_ext_reg #(
  parameter int           W     = 8,
  parameter logic [W-1:0] RESET = 8'h3F,
  localparam int          SEL_W = $clog2(W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             enter,
  input  logic             wr_en,
  input  logic [SEL_W-1:0] wr_sel,
  input  logic             wr_bit,
  output logic             mode,
  output logic [W-1:0]     value
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mode  <= 1'b0;
      value <= RESET;
    end else begin
      if (enter) mode <= 1'b1;
      if (wr_en) value[wr_sel] <= wr_bit;
    end
  end
endmodule

// File: rtl/cfg_stage_regs.sv
module cfg_stage_regs
  import cfg_stage_pkg::*;
#(
  parameter int                ADDR_W    = 24,
  parameter int                DATA_W    = 8,
  parameter int                IDX_LSB   = 16,
  parameter logic [ADDR_W-1:0] WIN_MASK  = 24'hF0F000,
  parameter logic [ADDR_W-1:0] WIN_MATCH = 24'h005000,
  parameter int                EXT_W     = 8,
  parameter logic [EXT_W-1:0]  EXT_RESET = 8'h3F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_rdata_in,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              irq_set,
  output logic              irq_flag,
  output logic              irq_enable,
  output logic              cfg_map_a15,
  output logic              cfg_psram_lo_en,
  output logic              cfg_psram_hi_en,
  output logic [1:0]        cfg_psram_win,
  output logic              cfg_rom_lo_en,
  output logic              cfg_rom_hi_en,
  output logic              cfg_exp_lo_en,
  output logic              cfg_exp_hi_en,
  output logic              cfg_exp_win,
  output logic              cfg_flash_wr_en,
  output logic              cfg_spare
);
  localparam int IDX_W       = 4;
  localparam int STAGE_SEL_W = $clog2(STAGE_N);
  localparam int EXT_SEL_W   = $clog2(EXT_W);

  // Named internal events, observed by the bound checker.
  logic              win_hit;
  logic [IDX_W-1:0]  win_idx;
  logic              wr_hit, rd_hit, norm_wr, ext_wr;
  logic              stage_wr, commit_evt, ext_enter, irq_en_wr;
  logic              wr_bit;
  logic [DATA_W-2:0] unused_wdata;
  logic [IDX_W-1:0]  stage_off;
  logic [STAGE_N-1:0] pend_vec, act_vec;
  logic              ext_mode;
  logic [EXT_W-1:0]  ext_value;
  logic              rd_bit;
  cfg_t              cfg;

  cfg_win_decode #(
    .ADDR_W(ADDR_W), .IDX_W(IDX_W), .IDX_LSB(IDX_LSB),
    .WIN_MASK(WIN_MASK), .WIN_MATCH(WIN_MATCH)
  ) u_dec (
    .addr(bus_addr), .hit(win_hit), .idx(win_idx)
  );

  assign wr_bit       = bus_wdata[DATA_W-1];
  assign unused_wdata = bus_wdata[DATA_W-2:0];
  assign wr_hit       = bus_wr && win_hit;
  assign rd_hit       = bus_rd && win_hit;
  assign norm_wr      = wr_hit && !ext_mode;
  assign ext_wr       = wr_hit && ext_mode;
  assign stage_off    = win_idx - IDX_W'(STAGE_FIRST);
  assign stage_wr     = norm_wr && idx_is_staged(win_idx);
  assign commit_evt   = norm_wr && (win_idx == IDX_W'(COMMIT_IDX)) && wr_bit;
  assign ext_enter    = norm_wr && (win_idx == IDX_W'(EXT_IDX)) && wr_bit;
  assign irq_en_wr    = norm_wr && (win_idx == IDX_W'(IRQ_EN_IDX));

  cfg_stage_bank #(.N(STAGE_N), .RESET(STAGE_RESET)) u_bank (
    .clk(clk), .rst(rst), .wr_en(stage_wr),
    .wr_sel(stage_off[STAGE_SEL_W-1:0]), .wr_bit(wr_bit),
    .commit(commit_evt), .pend(pend_vec), .act(act_vec)
  );

  cfg_ext_reg #(.W(EXT_W), .RESET(EXT_RESET)) u_ext (
    .clk(clk), .rst(rst), .enter(ext_enter), .wr_en(ext_wr),
    .wr_sel(win_idx[EXT_SEL_W-1:0]), .wr_bit(wr_bit),
    .mode(ext_mode), .value(ext_value)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_flag   <= 1'b0;
      irq_enable <= 1'b0;
    end else begin
      if (irq_set)   irq_flag   <= 1'b1;
      if (irq_en_wr) irq_enable <= wr_bit;
    end
  end

  always_comb begin
    rd_bit = 1'b0;
    if (ext_mode)                                 rd_bit = ext_value[win_idx[EXT_SEL_W-1:0]];
    else if (win_idx == IDX_W'(IRQ_FLAG_IDX))     rd_bit = irq_flag;
    else if (win_idx == IDX_W'(IRQ_EN_IDX))       rd_bit = irq_enable;
    else if (idx_is_staged(win_idx))              rd_bit = act_vec[stage_off[STAGE_SEL_W-1:0]];
  end

  assign bus_rdata = rd_hit ? {rd_bit, {(DATA_W-1){1'b0}}} : bus_rdata_in;

  assign cfg             = cfg_from_vec(act_vec);
  assign cfg_map_a15     = cfg.map_a15;
  assign cfg_psram_lo_en = cfg.psram_lo;
  assign cfg_psram_hi_en = cfg.psram_hi;
  assign cfg_psram_win   = cfg.psram_win;
  assign cfg_rom_lo_en   = cfg.rom_lo;
  assign cfg_rom_hi_en   = cfg.rom_hi;
  assign cfg_exp_lo_en   = cfg.exp_lo;
  assign cfg_exp_hi_en   = cfg.exp_hi;
  assign cfg_exp_win     = cfg.exp_win;
  assign cfg_flash_wr_en = cfg.flash_wr;
  assign cfg_spare       = cfg.spare;
endmodule

// File: rtl/cfg_stage_regs_chk.sv
module cfg_stage_regs_chk #(
  parameter int DATA_W  = 8,
  parameter int STAGE_N = 12
) (
  input logic               clk,
  input logic               rst,
  input logic               win_hit,
  input logic               bus_rd,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic [DATA_W-1:0]  bus_rdata_in,
  input logic               commit_evt,
  input logic               stage_wr,
  input logic               ext_wr,
  input logic               ext_mode,
  input logic               irq_en_wr,
  input logic               wr_bit,
  input logic               irq_enable,
  input logic [STAGE_N-1:0] pend_vec,
  input logic [STAGE_N-1:0] act_vec
);
  // R4: a commit makes the active copy equal to the pending copy of that cycle
  a_r4_commit_copies: assert property (@(posedge clk) disable iff (rst)
    commit_evt |=> (act_vec == $past(pend_vec)));

  // R3: a staged write without commit leaves the active copy alone
  a_r3_stage_only_pending: assert property (@(posedge clk) disable iff (rst)
    (stage_wr && !commit_evt) |=> $stable(act_vec));

  // R8: extended mode is sticky
  a_r8_ext_sticky: assert property (@(posedge clk) disable iff (rst)
    ext_mode |=> ext_mode);

  // R9: redirected writes touch neither copy of the configuration
  a_r9_ext_keeps_cfg: assert property (@(posedge clk) disable iff (rst)
    ext_wr |=> ($stable(act_vec) && $stable(pend_vec)));

  // R11: pass-through outside the window
  a_r11_passthru: assert property (@(posedge clk) disable iff (rst)
    !win_hit |-> (bus_rdata == bus_rdata_in));

  // R2: only bit 7 can be set on a window read
  a_r2_read_format: assert property (@(posedge clk) disable iff (rst)
    (win_hit && bus_rd) |-> (bus_rdata[DATA_W-2:0] == '0));

  // R6: the interrupt enable follows its write with no commit
  a_r6_irq_en_direct: assert property (@(posedge clk) disable iff (rst)
    irq_en_wr |=> (irq_enable == $past(wr_bit)));
endmodule

bind cfg_stage_regs cfg_stage_regs_chk #(.DATA_W(DATA_W), .STAGE_N(STAGE_N)) u_chk (
  .clk(clk), .rst(rst), .win_hit(win_hit), .bus_rd(bus_rd),
  .bus_rdata(bus_rdata), .bus_rdata_in(bus_rdata_in),
  .commit_evt(commit_evt), .stage_wr(stage_wr), .ext_wr(ext_wr),
  .ext_mode(ext_mode), .irq_en_wr(irq_en_wr), .wr_bit(wr_bit),
  .irq_enable(irq_enable), .pend_vec(pend_vec), .act_vec(act_vec)
);

// File: tb/tb_cfg_stage_regs.sv
module tb_cfg_stage_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [23:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_rdata_in = 8'h5A;
  logic [7:0]  bus_rdata;
  logic        irq_set = 1'b0;
  logic        irq_flag, irq_enable;
  logic        cfg_map_a15, cfg_psram_lo_en, cfg_psram_hi_en;
  logic [1:0]  cfg_psram_win;
  logic        cfg_rom_lo_en, cfg_rom_hi_en, cfg_exp_lo_en, cfg_exp_hi_en;
  logic        cfg_exp_win, cfg_flash_wr_en, cfg_spare;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  cfg_stage_regs dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_rdata_in(bus_rdata_in),
    .bus_rdata(bus_rdata), .irq_set(irq_set), .irq_flag(irq_flag),
    .irq_enable(irq_enable), .cfg_map_a15(cfg_map_a15),
    .cfg_psram_lo_en(cfg_psram_lo_en), .cfg_psram_hi_en(cfg_psram_hi_en),
    .cfg_psram_win(cfg_psram_win), .cfg_rom_lo_en(cfg_rom_lo_en),
    .cfg_rom_hi_en(cfg_rom_hi_en), .cfg_exp_lo_en(cfg_exp_lo_en),
    .cfg_exp_hi_en(cfg_exp_hi_en), .cfg_exp_win(cfg_exp_win),
    .cfg_flash_wr_en(cfg_flash_wr_en), .cfg_spare(cfg_spare)
  );

  // Outputs packed: {irq_flag, irq_en, spare, flash, exwin, exhi, exlo, romhi, romlo, pwin[1:0], phi, plo, map}
  function automatic logic [13:0] outs();
    return {irq_flag, irq_enable, cfg_spare, cfg_flash_wr_en, cfg_exp_win,
            cfg_exp_hi_en, cfg_exp_lo_en, cfg_rom_hi_en, cfg_rom_lo_en,
            cfg_psram_win, cfg_psram_hi_en, cfg_psram_lo_en, cfg_map_a15};
  endfunction

  function automatic logic [23:0] reg_addr(input logic [3:0] idx, input logic [11:0] off);
    return {4'h0, idx, 4'h5, off};
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr_at(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_at(input logic [23:0] a, input string req, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1;
    check(req, {24'h0, bus_rdata}, {24'h0, exp});
    bus_rd = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  typedef struct packed {
    bit       wr;
    bit [3:0] idx;
    bit [7:0] d;    // write data, or expected read data
    bit [3:0] req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 4'd2,  8'h80, 4'd10}, // R10 mapping resets to 1
    '{1'b0, 4'd4,  8'h00, 4'd10}, // R10 PSRAM high resets to 0
    '{1'b1, 4'd2,  8'h00, 4'd3 },
    '{1'b0, 4'd2,  8'h80, 4'd3 }, // R3 still reads active
    '{1'b1, 4'd4,  8'h80, 4'd3 },
    '{1'b0, 4'd4,  8'h00, 4'd3 }, // R3
    '{1'b1, 4'd14, 8'h00, 4'd4 }, // commit with bit 7 clear
    '{1'b0, 4'd2,  8'h80, 4'd4 }, // R4 nothing copied
    '{1'b1, 4'd14, 8'h80, 4'd4 },
    '{1'b0, 4'd2,  8'h00, 4'd4 }, // R4 copied
    '{1'b0, 4'd4,  8'h80, 4'd4 }, // R4 copied
    '{1'b0, 4'd14, 8'h00, 4'd5 }, // R5
    '{1'b0, 4'd15, 8'h00, 4'd5 }, // R5
    '{1'b1, 4'd1,  8'h80, 4'd6 },
    '{1'b0, 4'd1,  8'h80, 4'd6 }, // R6 enable direct
    '{1'b1, 4'd0,  8'h80, 4'd6 },
    '{1'b0, 4'd0,  8'h00, 4'd6 }  // R6 flag ignores writes
  };

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++; n_cmp++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    do_reset();
    @(negedge clk); #1;
    // R10: reset state at the ports
    check("R10", {18'h0, outs()}, {18'h0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1,
                                   1'b1, 1'b1, 2'b11, 1'b0, 1'b1, 1'b1});
    check("R11", {24'h0, bus_rdata}, 32'h5A); // no read strobe

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d", VECS[i].req);
      if (VECS[i].wr) wr_at(reg_addr(VECS[i].idx, 12'h000), VECS[i].d);
      else            rd_at(reg_addr(VECS[i].idx, 12'h000), tag, VECS[i].d);
    end

    // R4: outputs after the table commit (mapping 0, PSRAM high 1)
    @(negedge clk); #1;
    check("R4", {31'h0, cfg_map_a15}, 32'h0);
    check("R4", {31'h0, cfg_psram_hi_en}, 32'h1);

    // R7: window bits 5/6 and flash bit 12 land on their outputs after a commit
    wr_at(reg_addr(4'd5, 12'h000), 8'h00);
    wr_at(reg_addr(4'd6, 12'h000), 8'h80);
    wr_at(reg_addr(4'd12, 12'h000), 8'h7F);  // bit 7 clear: flash stays 0
    #1;
    check("R3", {30'h0, cfg_psram_win}, 32'h3);
    wr_at(reg_addr(4'd12, 12'h000), 8'h80);
    wr_at(reg_addr(4'd14, 12'h000), 8'h80);
    #1;
    check("R7", {30'h0, cfg_psram_win}, 32'h2);
    check("R7", {31'h0, cfg_flash_wr_en}, 32'h1);

    // R1: index from bits 19:16, low offset ignored, outside banks and offsets
    rd_at(24'h0C5FFF, "R1", 8'h80);
    rd_at(24'h075ABC, "R1", 8'h80);
    rd_at(24'h105000, "R1", 8'h5A);
    rd_at(24'h006000, "R11", 8'h5A);

    // R6: flag set by irq_set
    @(negedge clk); irq_set = 1'b1;
    @(negedge clk); irq_set = 1'b0;
    rd_at(reg_addr(4'd0, 12'h000), "R6", 8'h80);

    // R8/R9: extended mode after a committed change
    wr_at(reg_addr(4'd15, 12'h000), 8'h80);
    rd_at(reg_addr(4'd0,  12'h000), "R9", 8'h80); // ext bit 0 of 0x3F
    rd_at(reg_addr(4'd8,  12'h000), "R9", 8'h80); // 8 AND 7 = bit 0
    rd_at(reg_addr(4'd6,  12'h000), "R9", 8'h00); // ext bit 6, not window bit
    rd_at(reg_addr(4'd15, 12'h000), "R8", 8'h00); // ext bit 7
    wr_at(reg_addr(4'd14, 12'h000), 8'h80);       // sets ext bit 6, no commit
    #1;
    check("R9", {30'h0, cfg_psram_win}, 32'h2);
    rd_at(reg_addr(4'd6, 12'h000), "R9", 8'h80);
    wr_at(reg_addr(4'd15, 12'h000), 8'h00);       // clears ext bit 7, mode stays
    rd_at(reg_addr(4'd10, 12'h000), "R8", 8'h80); // ext bit 2 still 1
    wr_at(reg_addr(4'd10, 12'h000), 8'h00);
    rd_at(reg_addr(4'd2, 12'h000), "R9", 8'h00);
    #1;
    check("R9", {31'h0, cfg_exp_hi_en}, 32'h0);

    // R10: only reset leaves extended mode
    do_reset();
    rd_at(reg_addr(4'd2, 12'h000),  "R10", 8'h80);
    rd_at(reg_addr(4'd15, 12'h000), "R10", 8'h00);
    rd_at(reg_addr(4'd0, 12'h000),  "R10", 8'h00);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule